// File: doc/BRIEF.md
# Cache Data RAM Parity Checker

This block checks every read from a cache data RAM against a side RAM that holds one stored parity bit per byte lane. A read-request strobe starts each read. The RAM returns data after a programmable number of extra wait cycles. The block waits exactly that long, then compares the computed parity of the 256-bit word against the 32 stored bits. It does this in that one cycle only, so values still settling on the buses in earlier cycles can never raise a false failure.

A mismatch is logged in a sticky raw status register. When the first error is logged, the per-lane mismatch vector is kept in a syndrome register. A mask register gates the raw status into a masked status. The OR of the masked bits drives a registered interrupt line. Software clears status by writing ones, and turns checking on and off with an enable bit. The latency field must be held constant while reads are in flight.

Top module: `dram_parity_guard`

## Requirements
- R1: Parity is even per byte: lane i covers `rd_data[8i+7:8i]` and is good when the XOR of those eight bits equals `rd_par[i]`. A mismatch in lane i shows as bit i of `syndrome`.
- R2: A request sampled on clock edge k is compared using the `rd_data`/`rd_par` values sampled on edge k+N+1, where N is `rd_lat`. Bus values on any other edge never affect status.
- R3: When `par_en` is 0 on the compare edge, no status bit changes. `par_en` is an input that the surrounding control register holds at 0 after its reset.
- R4: Raw status bit 0 (first error) is set by a failing compare and stays set. Raw status bit 1 (multiple errors) is set by a failing compare while bit 0 is already set and is not being cleared.
- R5: Writing `clr_wr` with a 1 in bit j of `clr_wdata` clears raw bit j. A set in the same cycle takes priority over the clear.
- R6: `masked_stat` equals `raw_stat` AND the mask. The mask is loaded from `mask_wdata` on `mask_wr` and resets to all zeros.
- R7: `par_irq` is the OR of `masked_stat`, registered, so it follows one cycle later.
- R8: `syndrome` captures the mismatch vector of the first error and holds it while raw bit 0 stays set. Clearing raw bit 0 without a new error zeros it.
- R9: Requests on consecutive cycles are each compared on their own edge.
- R10: After reset, `raw_stat`, `masked_stat`, `syndrome` and `par_irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Read request strobe to the data RAM |
| rd_data | input | 256 | Read data from the data RAM |
| rd_par | input | 32 | Stored parity bits from the side RAM |
| par_en | input | 1 | Parity checking enable |
| rd_lat | input | 3 | Extra read wait cycles N |
| mask_wr | input | 1 | Load strobe for the mask |
| mask_wdata | input | 2 | New mask value |
| clr_wr | input | 1 | Write-one-to-clear strobe |
| clr_wdata | input | 2 | Raw status bits to clear |
| raw_stat | output | 2 | Raw status: bit 0 first error, bit 1 multiple errors |
| masked_stat | output | 2 | Raw status gated by the mask |
| syndrome | output | 32 | Lane mismatch vector of the first error |
| par_irq | output | 1 | Registered parity-failure interrupt |

## Verification
A request sampled on edge k has its compare on edge k+N+1. `raw_stat`, `masked_stat` and `syndrome` show the result after that edge, and `par_irq` shows it one edge later. The bench drives inputs on falling edges and advances a fixed number of falling edges for each stimulus. It reads the status in the half-cycle after the compare edge, then checks the interrupt one cycle later. Any cycle that is not the compare cycle carries junk data with every lane's parity inverted, so a compare on the wrong edge shows up as a status change.

// File: rtl/dpg_pkg.sv
// Shared constants for the data RAM parity checker.
// Assumes status bit positions are fixed: software decodes them.
package dpg_pkg;
    localparam int NSRC      = 2;  // interrupt sources
    localparam int SRC_FIRST = 0;  // first parity error
    localparam int SRC_MULTI = 1;  // error while first error still held
endpackage

// File: rtl/dpg_read_tracker.sv
// Tracks reads in flight and raises the compare strobe exactly
// rd_lat+1 cycles after each request.
// Assumes rd_lat is held constant while reads are pending.
module dpg_read_tracker #(
    parameter int LAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [LAT_W-1:0] rd_lat,
    output logic             chk_stb
);
    localparam int DEPTH = 1 << LAT_W;

    logic [DEPTH-1:0] pend_q;

    // Stage 0 takes the new request; each later stage ages it by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q[0] <= 1'b0;
        else        pend_q[0] <= rd_req;
    end

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        // Moves a pending read one stage further on.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[s] <= 1'b0;
            else        pend_q[s] <= pend_q[s-1];
        end
    end

    // The stage matching the programmed latency is the data-valid cycle.
    assign chk_stb = pend_q[rd_lat];
endmodule

// File: rtl/dpg_lane_parity.sv
// Computes even parity for each byte lane and flags lanes whose stored
// parity bit disagrees. Purely combinational.
module dpg_lane_parity #(
    parameter int DATA_W = 256,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0]        rd_data,
    input  logic [DATA_W/LANE_W-1:0] rd_par,
    output logic [DATA_W/LANE_W-1:0] mism
);
    localparam int NLANE = DATA_W / LANE_W;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        // A lane mismatches when its XOR differs from the stored bit.
        assign mism[i] = (^rd_data[i*LANE_W +: LANE_W]) ^ rd_par[i];
    end
endmodule

// File: rtl/dpg_irq_regs.sv
// Raw, mask and syndrome registers plus the registered interrupt.
// Assumes a set on the same cycle as a clear wins.
module dpg_irq_regs
    import dpg_pkg::*;
#(
    parameter int NLANE = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_hit,
    input  logic [NLANE-1:0] mism,
    input  logic             mask_wr,
    input  logic [NSRC-1:0]  mask_wdata,
    input  logic             clr_wr,
    input  logic [NSRC-1:0]  clr_wdata,
    output logic [NSRC-1:0]  raw_stat,
    output logic [NSRC-1:0]  masked_stat,
    output logic [NSRC-1:0]  mask_q,
    output logic [NLANE-1:0] syndrome,
    output logic             par_irq
);
    logic [NSRC-1:0]  raw_q;
    logic [NSRC-1:0]  clr;
    logic [NLANE-1:0] syn_q;
    logic             err_now;
    logic             first_free;
    logic             irq_q;

    // Decode the error event and whether the first-error slot is free.
    always_comb begin
        clr        = clr_wr ? clr_wdata : '0;
        err_now    = cmp_hit && (|mism);
        first_free = !raw_q[SRC_FIRST] || clr[SRC_FIRST];
    end

    // Sticky raw status with write-one-to-clear; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q[SRC_FIRST] <= (raw_q[SRC_FIRST] & ~clr[SRC_FIRST]) | err_now;
            raw_q[SRC_MULTI] <= (raw_q[SRC_MULTI] & ~clr[SRC_MULTI])
                              | (err_now & ~first_free);
        end
    end

    // Syndrome holds the first error's lane vector until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)                    syn_q <= '0;
        else if (err_now && first_free) syn_q <= mism;
        else if (clr[SRC_FIRST])       syn_q <= '0;
    end

    // Mask register, all sources masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    // Registered interrupt so the line never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(raw_q & mask_q);
    end

    assign raw_stat    = raw_q;
    assign masked_stat = raw_q & mask_q;
    assign syndrome    = syn_q;
    assign par_irq     = irq_q;
endmodule

// File: rtl/dram_parity_guard.sv
// Top of the data RAM parity checker: latency tracking, lane parity
// compare on the data-valid cycle only, and interrupt registers.
// Assumes rd_lat is static while reads are in flight.
module dram_parity_guard
    import dpg_pkg::*;
#(
    parameter int DATA_W = 256,
    parameter int LANE_W = 8,
    parameter int LAT_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_req,
    input  logic [DATA_W-1:0]        rd_data,
    input  logic [DATA_W/LANE_W-1:0] rd_par,
    input  logic                     par_en,
    input  logic [LAT_W-1:0]         rd_lat,
    input  logic                     mask_wr,
    input  logic [NSRC-1:0]          mask_wdata,
    input  logic                     clr_wr,
    input  logic [NSRC-1:0]          clr_wdata,
    output logic [NSRC-1:0]          raw_stat,
    output logic [NSRC-1:0]          masked_stat,
    output logic [DATA_W/LANE_W-1:0] syndrome,
    output logic                     par_irq
);
    localparam int NLANE = DATA_W / LANE_W;

    logic             chk_stb;
    logic             cmp_hit;
    logic [NLANE-1:0] mism;
    logic [NSRC-1:0]  mask_q;

    dpg_read_tracker #(.LAT_W(LAT_W)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .rd_lat  (rd_lat),
        .chk_stb (chk_stb)
    );

    dpg_lane_parity #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_par (
        .rd_data (rd_data),
        .rd_par  (rd_par),
        .mism    (mism)
    );

    // A compare counts only when checking is enabled.
    assign cmp_hit = chk_stb && par_en;

    dpg_irq_regs #(.NLANE(NLANE)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_hit     (cmp_hit),
        .mism        (mism),
        .mask_wr     (mask_wr),
        .mask_wdata  (mask_wdata),
        .clr_wr      (clr_wr),
        .clr_wdata   (clr_wdata),
        .raw_stat    (raw_stat),
        .masked_stat (masked_stat),
        .mask_q      (mask_q),
        .syndrome    (syndrome),
        .par_irq     (par_irq)
    );
endmodule

// File: rtl/dpg_checker.sv
// Property checker for dram_parity_guard, attached by bind below.
module dpg_checker
    import dpg_pkg::*;
#(
    parameter int NLANE = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chk_stb,
    input logic             par_en,
    input logic             clr_wr,
    input logic [NSRC-1:0]  clr_wdata,
    input logic [NSRC-1:0]  mask_q,
    input logic [NSRC-1:0]  raw_stat,
    input logic [NSRC-1:0]  masked_stat,
    input logic [NLANE-1:0] syndrome,
    input logic             par_irq
);
    // A new first error only arises from an enabled compare cycle.
    assert_set_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_stat[SRC_FIRST]) |-> $past(chk_stb && par_en));

    // Disabled checking with no clear leaves the status untouched.
    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_en && !clr_wr) |=> $stable(raw_stat));

    // The first-error bit is sticky until cleared.
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat[SRC_FIRST] && !(clr_wr && clr_wdata[SRC_FIRST]))
        |=> raw_stat[SRC_FIRST]);

    // Masked status never shows a bit that is not raw or not unmasked.
    assert_mask_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_stat & ~(raw_stat & mask_q)) == '0);

    // Interrupt follows the masked status one cycle later.
    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|masked_stat) |=> par_irq);
    assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|masked_stat) |=> !par_irq);

    // Syndrome holds while the first error is held.
    assert_syndrome_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat[SRC_FIRST] && !(clr_wr && clr_wdata[SRC_FIRST]))
        |=> $stable(syndrome));
endmodule

bind dram_parity_guard dpg_checker #(.NLANE(NLANE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk_stb     (chk_stb),
    .par_en      (par_en),
    .clr_wr      (clr_wr),
    .clr_wdata   (clr_wdata),
    .mask_q      (mask_q),
    .raw_stat    (raw_stat),
    .masked_stat (masked_stat),
    .syndrome    (syndrome),
    .par_irq     (par_irq)
);

// File: tb/sim_dram_parity_guard.sv
module sim_dram_parity_guard;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_req = 1'b0;
    logic [255:0] rd_data = '0;
    logic [31:0]  rd_par = '0;
    logic         par_en = 1'b0;
    logic [2:0]   rd_lat = '0;
    logic         mask_wr = 1'b0;
    logic [1:0]   mask_wdata = '0;
    logic         clr_wr = 1'b0;
    logic [1:0]   clr_wdata = '0;
    logic [1:0]   raw_stat, masked_stat;
    logic [31:0]  syndrome;
    logic         par_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dram_parity_guard u0 (.*);

    localparam logic [255:0] JUNK = {8{32'hdead_beef}};

    // {latency[2:0], lane flip mask[31:0], data seed[31:0]}
    localparam logic [66:0] VEC [6] = '{
        {3'd0, 32'h0000_0000, 32'h1234_5678},
        {3'd0, 32'h0000_0001, 32'h0f0f_a5a5},
        {3'd1, 32'h0000_0000, 32'hffff_0001},
        {3'd3, 32'h8000_0001, 32'h5555_aaaa},
        {3'd7, 32'h0000_0000, 32'h0000_0000},
        {3'd7, 32'hffff_ffff, 32'hc001_d00d}
    };

    function automatic logic [31:0] even_par(input logic [255:0] d);
        logic [31:0] p;
        for (int i = 0; i < 32; i++) p[i] = ^d[i*8 +: 8];
        return p;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic drive_junk();
        rd_data = JUNK;
        rd_par  = ~even_par(JUNK);
    endtask

    // One read: request, junk for N cycles, valid data, then junk.
    // Returns at the falling edge just after the compare edge.
    task automatic do_read(input logic [2:0] lat, input logic [255:0] d,
                           input logic [31:0] flip);
        @(negedge clk);
        rd_lat = lat; rd_req = 1'b1; drive_junk();
        @(negedge clk);
        rd_req = 1'b0;
        repeat (lat) @(negedge clk);
        rd_data = d; rd_par = even_par(d) ^ flip;
        @(negedge clk);
        drive_junk();
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_wr = 1'b1; clr_wdata = 2'b11;
        @(negedge clk);
        clr_wr = 1'b0; clr_wdata = '0;
        @(negedge clk);
    endtask

    task automatic set_mask(input logic [1:0] m);
        @(negedge clk);
        mask_wr = 1'b1; mask_wdata = m;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        drive_junk();
        repeat (3) @(negedge clk);
        // R10: reset values
        check("R10 raw", raw_stat, 0);
        check("R10 masked", masked_stat, 0);
        check("R10 syndrome", syndrome, 0);
        check("R10 irq", par_irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: checking disabled, bad parity ignored
        do_read(3'd2, {8{32'h0102_0304}}, 32'h0000_00ff);
        check("R3 disabled raw", raw_stat, 0);
        check("R3 disabled syndrome", syndrome, 0);

        par_en = 1'b1;
        set_mask(2'b11);

        // R1 R2 R4 R7 R8: table walk; junk around valid cycle has all lanes bad
        for (int v = 0; v < 6; v++) begin
            logic [2:0]   lat;
            logic [31:0]  flip;
            logic [255:0] d;
            lat  = VEC[v][66:64];
            flip = VEC[v][63:32];
            d    = {8{VEC[v][31:0]}} ^ {8{32'(v)}};
            do_read(lat, d, flip);
            check($sformatf("R2 R4 raw v%0d", v), raw_stat, {1'b0, flip != 0});
            check($sformatf("R1 R8 syndrome v%0d", v), syndrome, flip);
            check($sformatf("R7 irq not yet v%0d", v), par_irq, 0);
            @(negedge clk);
            check($sformatf("R7 irq v%0d", v), par_irq, flip != 0);
            clear_all();
        end

        // R4 R8: second error sets multi bit, syndrome keeps first
        do_read(3'd1, {8{32'h3333_cccc}}, 32'h0000_0010);
        do_read(3'd0, {8{32'h7777_1111}}, 32'h0200_0000);
        check("R4 multi raw", raw_stat, 2'b11);
        check("R8 syndrome kept", syndrome, 32'h0000_0010);

        // R5: clear only the multi bit, then the first bit
        @(negedge clk);
        clr_wr = 1'b1; clr_wdata = 2'b10;
        @(negedge clk);
        clr_wr = 1'b0;
        check("R5 partial clear", raw_stat, 2'b01);
        clr_wr = 1'b1; clr_wdata = 2'b01;
        @(negedge clk);
        clr_wr = 1'b0;
        check("R5 full clear", raw_stat, 2'b00);
        check("R8 syndrome zeroed", syndrome, 0);

        // R5: set wins over a same-cycle clear
        @(negedge clk);
        rd_lat = 3'd0; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        rd_data = {8{32'h0}}; rd_par = 32'h0000_0004;
        clr_wr = 1'b1; clr_wdata = 2'b01;
        @(negedge clk);
        clr_wr = 1'b0; drive_junk();
        check("R5 set wins", raw_stat, 2'b01);
        check("R5 set wins syndrome", syndrome, 32'h0000_0004);
        clear_all();

        // R6 R7: masked source keeps raw, hides masked and irq
        set_mask(2'b00);
        do_read(3'd4, {8{32'h2468_ace0}}, 32'h0001_0000);
        check("R6 raw under mask", raw_stat, 2'b01);
        check("R6 masked zero", masked_stat, 0);
        @(negedge clk);
        check("R7 irq masked", par_irq, 0);
        set_mask(2'b01);
        check("R6 masked after unmask", masked_stat, 2'b01);
        @(negedge clk);
        check("R7 irq after unmask", par_irq, 1);
        clear_all();

        // R9: back-to-back requests at latency 2, second one bad
        @(negedge clk);
        rd_lat = 3'd2; rd_req = 1'b1; drive_junk();
        @(negedge clk);
        @(negedge clk);
        rd_req = 1'b0;
        @(negedge clk);
        rd_data = {8{32'h1111_2222}}; rd_par = even_par({8{32'h1111_2222}});
        @(negedge clk);
        check("R9 first read clean", raw_stat, 0);
        rd_data = {8{32'h9999_8888}}; rd_par = even_par({8{32'h9999_8888}}) ^ 32'h0000_0004;
        @(negedge clk);
        drive_junk();
        check("R9 second read raw", raw_stat, 2'b01);
        check("R9 second read syndrome", syndrome, 32'h0000_0004);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule